// File: doc/BRIEF.md
# Reservation Tracker for Reserved Loads and Conditional Stores

This block tracks the single address reservation that pairs a reserved load with a later conditional store. It serves 4-byte (word) and 8-byte (doubleword) accesses. A decoded request carries these fields:
- the operation (reserved load or conditional store);
- the access size;
- the effective address;
- the store data;
- a flag that selects 32-bit addressing;
- the current summary-overflow bit.

Requests arrive one at a time on a valid/ready handshake. The block first checks alignment, then forms the working address, then issues one memory read or write on a simple request/acknowledge port. It returns the loaded data, or a 4-bit condition field for a conditional store, with a single-cycle `done` pulse.

A reserved load records its working address as the reservation. A conditional store succeeds only if its working address equals that recorded address exactly and the reservation is valid. Only then does it write memory. Every conditional store that passes the alignment check removes the reservation, whether it succeeds or not. A misaligned request completes immediately with a fault. It leaves memory and the reservation untouched.

Top module: `resv_unit`

## Requirements
- R1: A word request (`req_dword`=0) with `req_addr[1:0]` not zero completes in the same cycle it is offered, with `done`=1, `fault`=1, `cr_field`=0 and `rdata`=0. No memory request follows.
- R2: A doubleword request (`req_dword`=1) with `req_addr[2:0]` not zero faults exactly as in R1.
- R3: A faulting request leaves the reservation unchanged. A reserved address stays usable by a later, aligned conditional store.
- R4: When `req_mode32`=1, the working address is the request address with bits [63:32] forced to zero. The working address drives `mem_addr` and is both recorded and compared as the reservation. Alignment is judged on the untruncated request address.
- R5: A reserved load issues a read (`mem_we`=0) at the working address, with `mem_wide` equal to the size. `done` rises in the cycle after `mem_ack`, with `fault`=0 and `cr_field`=0. `rdata` holds the low 32 bits of `mem_rdata` zero-extended for a word, or all 64 bits for a doubleword.
- R6: A completed reserved load makes the reservation valid, holding its working address.
- R7: A conditional store issues a write (`mem_we`=1) only when the reservation is valid and equal to its working address. For a word, `mem_wdata` is the low 32 bits of the store data zero-extended. A store without a match finishes one cycle after acceptance and raises no memory request.
- R8: The condition field of a conditional store uses bit 3 = LT = 0, bit 2 = GT = 0, bit 1 = EQ = store performed, and bit 0 = SO = the `req_so` value given with the request.
- R9: After any aligned conditional store, successful or not, the reservation is invalid. A second conditional store to the same address fails.
- R10: After reset, `req_ready`=1, `done`=0 and `mem_req`=0, and no reservation is held. A conditional store then fails.
- R11: `req_ready` is low while a request is in flight. `done` is never high while `mem_req` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block can accept a request |
| req_op | input | 1 | 0 = reserved load, 1 = conditional store |
| req_dword | input | 1 | 1 = 8-byte access, 0 = 4-byte access |
| req_addr | input | 64 | Effective address |
| req_wdata | input | 64 | Store data |
| req_mode32 | input | 1 | 32-bit addressing: clear address bits [63:32] |
| req_so | input | 1 | Summary-overflow bit copied into the condition field |
| mem_req | output | 1 | Memory access pending |
| mem_we | output | 1 | 1 = write, 0 = read |
| mem_wide | output | 1 | 1 = 8-byte access |
| mem_addr | output | 64 | Memory address |
| mem_wdata | output | 64 | Memory write data |
| mem_ack | input | 1 | Memory access finished |
| mem_rdata | input | 64 | Memory read data, valid with `mem_ack` |
| done | output | 1 | Completion pulse |
| fault | output | 1 | Alignment fault, valid with `done` |
| rdata | output | 64 | Loaded value, valid with `done` |
| cr_field | output | 4 | Conditional-store condition field, valid with `done` |

## Verification
The alignment check and the reservation compare both act in the acceptance cycle. They collide when a misaligned conditional store carries the reserved address itself. The bench provokes this with a word reserved load at an address that is 4 mod 8, followed by a doubleword conditional store to that same address. The address matches the reservation but is misaligned for the doubleword size. The store must fault with no memory request, and a following word conditional store to that address must then succeed, which shows that the fault won and the reservation survived.

// File: rtl/resv_pkg.sv
package resv_pkg;

  typedef enum logic {
    OP_LRES  = 1'b0,
    OP_SCOND = 1'b1
  } resv_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MEM  = 2'd1,
    ST_RESP = 2'd2
  } resv_state_e;

  localparam int CR_SO = 0;
  localparam int CR_EQ = 1;
  localparam int CR_GT = 2;
  localparam int CR_LT = 3;

  // Condition field of a conditional store: only SO and EQ can be set.
  function automatic logic [3:0] cr_build(logic so, logic eq);
    logic [3:0] c;
    c        = '0;
    c[CR_SO] = so;
    c[CR_EQ] = eq;
    c[CR_GT] = 1'b0;
    c[CR_LT] = 1'b0;
    return c;
  endfunction

endpackage

// File: rtl/resv_align_chk.sv
module resv_align_chk #(
  parameter int ADDR_W = 64
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              dword,
  input  logic              mode32,
  output logic              misaligned,
  output logic [ADDR_W-1:0] eff_addr
);
  localparam int HI_W = ADDR_W - 32;

  function automatic logic low_bits_bad(logic [2:0] lo, logic dw);
    if (dw) return (lo != 3'b000);
    return (lo[1:0] != 2'b00);
  endfunction

  function automatic logic [ADDR_W-1:0] narrow(logic [ADDR_W-1:0] a, logic m32);
    if (m32) return {{HI_W{1'b0}}, a[31:0]};
    return a;
  endfunction

  // Alignment is judged on the untruncated address.
  always_comb begin
    misaligned = low_bits_bad(addr[2:0], dword);
    eff_addr   = narrow(addr, mode32);
  end

endmodule

// File: rtl/resv_store.sv
module resv_store #(
  parameter int ADDR_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_en,
  input  logic [ADDR_W-1:0] set_addr,
  input  logic              inval,
  input  logic [ADDR_W-1:0] cmp_addr,
  output logic              valid,
  output logic [ADDR_W-1:0] addr_q,
  output logic              hit
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid  <= 1'b0;
      addr_q <= '1;
    end else if (inval) begin
      valid  <= 1'b0;
      addr_q <= '1;
    end else if (set_en) begin
      valid  <= 1'b1;
      addr_q <= set_addr;
    end
  end

  // Separate valid flag: all-ones can never match by accident.
  always_comb hit = valid && (addr_q == cmp_addr);

endmodule

// File: rtl/resv_ctrl.sv
module resv_ctrl
  import resv_pkg::*;
#(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_dword,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_so,
  input  logic              misaligned,
  input  logic [ADDR_W-1:0] eff_addr,
  input  logic              resv_hit,
  output logic              resv_set,
  output logic [ADDR_W-1:0] resv_set_addr,
  output logic              sc_accept,
  output logic              fault_evt,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [DATA_W-1:0] rdata,
  output logic [3:0]        cr_field
);
  localparam int WORD_W = 32;
  localparam int PAD_W  = DATA_W - WORD_W;

  function automatic logic [DATA_W-1:0] size_fit(logic [DATA_W-1:0] d, logic dw);
    if (dw) return d;
    return {{PAD_W{1'b0}}, d[WORD_W-1:0]};
  endfunction

  resv_state_e       state;
  resv_op_e          op_q;
  logic              dw_q, so_q, ok_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q, rdata_q;
  logic              accept_ok, need_mem, is_sc_in;

  always_comb begin
    is_sc_in  = (req_op == OP_SCOND);
    fault_evt = (state == ST_IDLE) && req_valid && misaligned;
    accept_ok = (state == ST_IDLE) && req_valid && !misaligned;
    sc_accept = accept_ok && is_sc_in;
    need_mem  = !is_sc_in || resv_hit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= ST_IDLE;
      op_q    <= OP_LRES;
      dw_q    <= 1'b0;
      so_q    <= 1'b0;
      ok_q    <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (accept_ok) begin
          op_q    <= resv_op_e'(req_op);
          dw_q    <= req_dword;
          so_q    <= req_so;
          ok_q    <= need_mem;
          addr_q  <= eff_addr;
          wdata_q <= size_fit(req_wdata, req_dword);
          rdata_q <= '0;
          state   <= need_mem ? ST_MEM : ST_RESP;
        end
        ST_MEM: if (mem_ack) begin
          if (op_q == OP_LRES) rdata_q <= size_fit(mem_rdata, dw_q);
          state <= ST_RESP;
        end
        ST_RESP: state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    req_ready     = (state == ST_IDLE);
    mem_req       = (state == ST_MEM);
    mem_we        = (op_q == OP_SCOND);
    mem_wide      = dw_q;
    mem_addr      = addr_q;
    mem_wdata     = wdata_q;
    resv_set      = (state == ST_MEM) && mem_ack && (op_q == OP_LRES);
    resv_set_addr = addr_q;
    done          = fault_evt || (state == ST_RESP);
    fault         = fault_evt;
    rdata         = (state == ST_RESP) ? rdata_q : '0;
    cr_field      = ((state == ST_RESP) && (op_q == OP_SCOND)) ? cr_build(so_q, ok_q) : 4'b0000;
  end

endmodule

// File: rtl/resv_unit.sv
module resv_unit #(
  parameter int ADDR_W = 64,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_op,
  input  logic              req_dword,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  logic              req_mode32,
  input  logic              req_so,
  output logic              mem_req,
  output logic              mem_we,
  output logic              mem_wide,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [DATA_W-1:0] rdata,
  output logic [3:0]        cr_field
);

  logic              misaligned;
  logic [ADDR_W-1:0] eff_addr;
  logic              resv_hit, resv_set, resv_valid, sc_accept, fault_evt;
  logic [ADDR_W-1:0] resv_set_addr, resv_addr;

  resv_align_chk #(.ADDR_W(ADDR_W)) u_align (
    .addr       (req_addr),
    .dword      (req_dword),
    .mode32     (req_mode32),
    .misaligned (misaligned),
    .eff_addr   (eff_addr)
  );

  resv_store #(.ADDR_W(ADDR_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_en   (resv_set),
    .set_addr (resv_set_addr),
    .inval    (sc_accept),
    .cmp_addr (eff_addr),
    .valid    (resv_valid),
    .addr_q   (resv_addr),
    .hit      (resv_hit)
  );

  resv_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk           (clk),
    .rst_n         (rst_n),
    .req_valid     (req_valid),
    .req_ready     (req_ready),
    .req_op        (req_op),
    .req_dword     (req_dword),
    .req_wdata     (req_wdata),
    .req_so        (req_so),
    .misaligned    (misaligned),
    .eff_addr      (eff_addr),
    .resv_hit      (resv_hit),
    .resv_set      (resv_set),
    .resv_set_addr (resv_set_addr),
    .sc_accept     (sc_accept),
    .fault_evt     (fault_evt),
    .mem_req       (mem_req),
    .mem_we        (mem_we),
    .mem_wide      (mem_wide),
    .mem_addr      (mem_addr),
    .mem_wdata     (mem_wdata),
    .mem_ack       (mem_ack),
    .mem_rdata     (mem_rdata),
    .done          (done),
    .fault         (fault),
    .rdata         (rdata),
    .cr_field      (cr_field)
  );

endmodule

// File: rtl/resv_checker.sv
module resv_checker #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_ready,
  input logic              mem_req,
  input logic              mem_ack,
  input logic              done,
  input logic              fault,
  input logic [3:0]        cr_field,
  input logic              fault_evt,
  input logic              sc_accept,
  input logic              resv_valid,
  input logic [ADDR_W-1:0] resv_addr
);

  p_fault_nomem_r1: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> !mem_req);

  p_fault_keep_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fault_evt |=> ($stable(resv_valid) && $stable(resv_addr)));

  p_ack_done_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && mem_ack) |=> (done && !fault));

  p_cr_upper_r8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (cr_field[3:2] == 2'b00));

  p_sc_inval_r9: assert property (@(posedge clk) disable iff (!rst_n)
    sc_accept |=> !resv_valid);

  p_busy_r11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (!done && !req_ready));

endmodule

bind resv_unit resv_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .req_ready  (req_ready),
  .mem_req    (mem_req),
  .mem_ack    (mem_ack),
  .done       (done),
  .fault      (fault),
  .cr_field   (cr_field),
  .fault_evt  (fault_evt),
  .sc_accept  (sc_accept),
  .resv_valid (resv_valid),
  .resv_addr  (resv_addr)
);

// File: tb/sim_resv_unit.sv
`timescale 1ns/1ps
module sim_resv_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_op = 1'b0, req_dword = 1'b0, req_mode32 = 1'b0, req_so = 1'b0;
  logic [63:0] req_addr = '0, req_wdata = '0;
  logic        req_ready, mem_req, mem_we, mem_wide, done, fault;
  logic [63:0] mem_addr, mem_wdata, rdata;
  logic        mem_ack = 1'b0;
  logic [63:0] mem_rdata = '0;
  logic [3:0]  cr_field;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  logic        mdl_valid = 1'b0;
  logic [63:0] mdl_addr = '1;

  always #10 clk = ~clk;

  resv_unit u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_op(req_op), .req_dword(req_dword), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_mode32(req_mode32), .req_so(req_so), .mem_req(mem_req), .mem_we(mem_we),
    .mem_wide(mem_wide), .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_ack(mem_ack),
    .mem_rdata(mem_rdata), .done(done), .fault(fault), .rdata(rdata), .cr_field(cr_field)
  );

  function automatic logic [63:0] pat(logic [63:0] a);
    return {~a[31:0], a[31:0] ^ 32'h5A5A_1234};
  endfunction

  function automatic logic [63:0] work_addr(logic [63:0] a, logic m32);
    return m32 ? (a & 64'h0000_0000_FFFF_FFFF) : a;
  endfunction

  function automatic logic bad_align(logic [63:0] a, logic dw);
    return dw ? (a % 8 != 0) : (a % 4 != 0);
  endfunction

  function automatic logic [63:0] sized(logic [63:0] d, logic dw);
    return dw ? d : (d & 64'h0000_0000_FFFF_FFFF);
  endfunction

  task automatic chk(input logic ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic run_op(input logic op, input logic dw, input logic [63:0] a, input logic [63:0] wd,
                        input logic m32, input logic so);
    logic        mis, access;
    logic [63:0] eff;
    int          d;
    mis    = bad_align(a, dw);
    eff    = work_addr(a, m32);
    access = (op == 1'b0) || (mdl_valid && mdl_addr == eff);
    @(negedge clk);
    req_valid = 1'b1; req_op = op; req_dword = dw; req_addr = a;
    req_wdata = wd; req_mode32 = m32; req_so = so;
    #1;
    chk(req_ready == 1'b1, "R11 ready when idle", 64'(req_ready), 64'd1);
    if (mis) begin
      chk(done && fault, dw ? "R2 dword fault" : "R1 word fault", {62'd0, done, fault}, 64'd3);
      chk(cr_field == 4'd0 && rdata == 64'd0, "R1 fault outputs zero", rdata | 64'(cr_field), 64'd0);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      #1;
      chk(!mem_req && !done, "R1 no access after fault", {62'd0, mem_req, done}, 64'd0);
      return;
    end
    chk(!done, "R11 no early done", 64'(done), 64'd0);
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    #1;
    if (op == 1'b1) mdl_valid = 1'b0;
    if (access) begin
      chk(mem_req && !req_ready, "R11 busy with request", {62'd0, mem_req, req_ready}, 64'd2);
      chk(mem_addr == eff, "R4 memory address", mem_addr, eff);
      chk(mem_we == op && mem_wide == dw, op ? "R7 write kind" : "R5 read kind",
          {62'd0, mem_we, mem_wide}, {62'd0, op, dw});
      if (op) chk(mem_wdata == sized(wd, dw), "R7 write data", mem_wdata, sized(wd, dw));
      d = $urandom_range(0, 2);
      for (int i = 0; i < d; i++) begin
        @(negedge clk);
        #1;
        chk(mem_req && !done, "R11 request held", {62'd0, mem_req, done}, 64'd2);
      end
      mem_ack = 1'b1; mem_rdata = pat(eff);
      @(posedge clk);
      @(negedge clk);
      mem_ack = 1'b0;
      #1;
    end else begin
      chk(!mem_req, "R7 no write on mismatch", 64'(mem_req), 64'd0);
    end
    chk(done && !fault, "R5 done after access", {62'd0, done, fault}, 64'd2);
    if (op == 1'b0) begin
      chk(rdata == sized(pat(eff), dw), "R5 load data", rdata, sized(pat(eff), dw));
      chk(cr_field == 4'd0, "R5 load cr zero", 64'(cr_field), 64'd0);
      mdl_valid = 1'b1; mdl_addr = eff;
    end else begin
      chk(cr_field == {2'b00, access, so}, "R8 condition field", 64'(cr_field), {60'd0, 2'b00, access, so});
    end
    @(posedge clk);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk(req_ready && !done && !mem_req, "R10 reset state", {61'd0, req_ready, done, mem_req}, 64'd4);

    run_op(1, 0, 64'h100, 64'h1111, 0, 1);            // R10: nothing reserved, fails, cr=0001
    run_op(0, 0, 64'h100, 0, 0, 0);                   // R6 reserve
    run_op(1, 0, 64'h100, 64'hDEAD_BEEF_CAFE_0001, 0, 0); // R7 success
    run_op(1, 0, 64'h100, 64'h2222, 0, 0);            // R9 second fails
    run_op(0, 0, 64'h102, 0, 0, 0);                   // R1
    run_op(1, 1, 64'h10C, 0, 0, 0);                   // R2
    run_op(0, 1, 64'h200, 0, 0, 0);
    run_op(1, 0, 64'h201, 64'h3, 0, 0);               // R3 fault keeps reservation
    run_op(1, 1, 64'h200, 64'h0123_4567_89AB_CDEF, 0, 1); // R3 then success
    run_op(0, 0, 64'hFFFF_0001_0000_0300, 0, 1, 0);  // R4 truncated reserve
    run_op(1, 0, 64'h300, 64'h55, 0, 0);              // R4 matches truncated
    run_op(0, 0, 64'h404, 0, 0, 0);                   // collision case
    run_op(1, 1, 64'h404, 64'h66, 0, 0);              // fault wins
    run_op(1, 0, 64'h404, 64'h77, 0, 1);              // reservation survived
    run_op(0, 1, 64'h500, 0, 0, 0);
    run_op(1, 1, 64'h508, 64'h88, 0, 1);              // R7 mismatch, R9 clears
    run_op(1, 1, 64'h500, 64'h99, 0, 0);              // R9 fails

    for (int n = 0; n < 400; n++) begin
      logic [63:0] a;
      a = {($urandom_range(0, 1) ? 32'h0000_0007 : 32'h0), 32'h1000 + 32'($urandom_range(0, 7) * 2)};
      run_op(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)), a,
             {$urandom, $urandom}, 1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
    end

    finished = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule